// File: doc/BRIEF.md
# Paged Address Translator with Page Protection

This block turns a 17-bit virtual word address into a 22-bit real word address and decides in the same lookup whether the access may proceed. A page holds 512 words. In mapped mode, the upper eight virtual address bits pick one of 256 loadable frame entries. Each entry is 13 bits wide, and it replaces the page number. In unmapped mode, the address passes straight through. The lowest sixteen virtual addresses name the general registers and skip every other step.

Two independent protection checks run beside the translation. The first is a per-virtual-page permission code, which applies only in mapped mode. The second is a lock held per 512-word real page across the lowest 128K real words. That lock is matched against a 2-bit key supplied with each request. The block reports a register-reference flag, a fault flag and a fault cause. It does not trap, and it does not hold the key itself.

Three write ports load the frame, permission and lock tables, one entry per cycle each. A lookup is presented with `req_valid`, and its result appears, registered, on the next clock cycle.

Top module: `page_map_guard`

## Requirements
- R1: A virtual address below 16 gives `res_regref`=1, `res_addr` equal to the zero-extended virtual address and `res_cause`=00, whatever the mode, tables, access kind or key.
- R2: In mapped mode (`map_on`=1), `res_addr` is the frame entry selected by virtual bits [16:9], followed by virtual bits [8:0].
- R3: In unmapped mode, `res_addr` is the virtual address zero-extended to 22 bits, and the permission code is ignored.
- R4: Access kind 00 is read, 01 is write, 10 is execute, and 11 is checked as a write. Permission code 00 allows everything. Code 01 allows read and execute. Code 10 allows read only. Code 11 allows nothing. A denied mapped access gives cause 01.
- R5: In both modes, the lock indexed by real address bits [16:9] is checked. Lock 00 is open, key 00 is the master key, and any other lock passes only with an equal key. A failure gives cause 10.
- R6: A real address of 2^17 or above skips the lock check.
- R7: `res_cause` is 00 for no fault, 01 for permission and 10 for lock. When both checks fail, 01 is reported. `res_fault` is 1 exactly when the cause is not 00.
- R8: The result of a lookup appears with `res_valid`=1 on the clock cycle after the one in which `req_valid` was sampled high. `res_valid` is 0 otherwise.
- R9: A lookup sampled in the same cycle as a table write uses the entry as it was before that write. The new entry is used from the next cycle on.
- R10: Reset clears every frame, permission and lock entry and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 17 | Virtual word address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| map_on | input | 1 | Mapped mode |
| psd_key | input | 2 | Protection key of the running program |
| frm_we | input | 1 | Frame table write enable |
| frm_idx | input | 8 | Frame table entry |
| frm_data | input | 13 | Frame number to load |
| perm_we | input | 1 | Permission table write enable |
| perm_idx | input | 8 | Permission table entry |
| perm_data | input | 2 | Permission code to load |
| lock_we | input | 1 | Lock table write enable |
| lock_idx | input | 8 | Lock table entry (real page) |
| lock_data | input | 2 | Lock code to load |
| res_valid | output | 1 | Result present |
| res_addr | output | 22 | Real word address |
| res_regref | output | 1 | Address names a general register |
| res_fault | output | 1 | Access refused |
| res_cause | output | 2 | 00 none, 01 permission, 10 lock |

## Verification
Every lookup result is due exactly one clock edge after the edge that samples the request. Table writes take effect at the edge that samples them, so their effect shows only in lookups sampled at later edges. The driver applies inputs on the falling edge and pushes the expected result into a queue at the same moment. The monitor pops and compares on the next falling edge, which follows the single register stage. A result that arrives with an empty queue, or a queue left non-empty at the end, counts as a timing mismatch.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    localparam int VA_W      = 17;
    localparam int OFF_W     = 9;
    localparam int FRAME_W   = 13;
    localparam int PA_W      = FRAME_W + OFF_W;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PAGES     = 1 << VPN_W;
    localparam int LOCK_W    = 17;
    localparam int NREG      = 16;
    localparam int CODE_W    = 2;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_EXEC  = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_PERM = 2'b01,
        CAUSE_LOCK = 2'b10
    } cause_e;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic            regref;
        cause_e          cause;
    } result_t;

    function automatic logic perm_allows(logic [CODE_W-1:0] code, kind_e kind);
        logic rd, wr, ex;
        rd = (code != 2'b11);
        wr = (code == 2'b00);
        ex = (code == 2'b00) || (code == 2'b01);
        case (kind)
            KIND_READ: return rd;
            KIND_EXEC: return ex;
            default:   return wr;
        endcase
    endfunction

    function automatic logic key_opens(logic [CODE_W-1:0] lock, logic [CODE_W-1:0] key);
        return (lock == '0) || (key == '0) || (lock == key);
    endfunction
endpackage

// File: rtl/pmm_table.sv
module pmm_table #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    ridx,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/pmm_xlate.sv
module pmm_xlate
    import pmm_pkg::*;
(
    input  logic [VA_W-1:0]    vaddr,
    input  logic               map_on,
    input  logic [FRAME_W-1:0] frame,
    output logic [PA_W-1:0]    real_addr,
    output logic               regref,
    output logic [VPN_W-1:0]   lock_page,
    output logic               lock_live
);
    localparam int HI_W = PA_W - LOCK_W;

    always_comb begin
        regref = (vaddr < VA_W'(NREG));
        if (regref || !map_on)
            real_addr = PA_W'(vaddr);
        else
            real_addr = {frame, vaddr[OFF_W-1:0]};
        lock_page = real_addr[LOCK_W-1:OFF_W];
        lock_live = (real_addr[PA_W-1:LOCK_W] == HI_W'(0));
    end
endmodule

// File: rtl/pmm_guard.sv
module pmm_guard
    import pmm_pkg::*;
(
    input  kind_e             kind,
    input  logic              map_on,
    input  logic              regref,
    input  logic [CODE_W-1:0] perm_code,
    input  logic [CODE_W-1:0] lock_code,
    input  logic [CODE_W-1:0] key,
    input  logic              lock_live,
    output cause_e            cause
);
    logic perm_bad, lock_bad;

    always_comb begin
        perm_bad = map_on && !perm_allows(perm_code, kind);
        lock_bad = lock_live && !key_opens(lock_code, key);
        if (regref)        cause = CAUSE_NONE;
        else if (perm_bad) cause = CAUSE_PERM;
        else if (lock_bad) cause = CAUSE_LOCK;
        else               cause = CAUSE_NONE;
    end
endmodule

// File: rtl/page_map_guard.sv
module page_map_guard
    import pmm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_kind,
    input  logic                  map_on,
    input  logic [CODE_W-1:0]     psd_key,
    input  logic                  frm_we,
    input  logic [VPN_W-1:0]      frm_idx,
    input  logic [FRAME_W-1:0]    frm_data,
    input  logic                  perm_we,
    input  logic [VPN_W-1:0]      perm_idx,
    input  logic [CODE_W-1:0]     perm_data,
    input  logic                  lock_we,
    input  logic [VPN_W-1:0]      lock_idx,
    input  logic [CODE_W-1:0]     lock_data,
    output logic                  res_valid,
    output logic [PA_W-1:0]       res_addr,
    output logic                  res_regref,
    output logic                  res_fault,
    output logic [1:0]            res_cause
);
    logic [VPN_W-1:0]   vpn;
    logic [FRAME_W-1:0] frame;
    logic [CODE_W-1:0]  perm_code, lock_code;
    logic [VPN_W-1:0]   lock_page;
    logic               lock_live;
    result_t            nxt, cur;

    assign vpn = req_vaddr[VA_W-1:OFF_W];

    pmm_table #(.WIDTH(FRAME_W), .DEPTH(PAGES)) u_frames (
        .clk(clk), .rst(rst), .we(frm_we), .widx(frm_idx), .wdata(frm_data),
        .ridx(vpn), .rdata(frame));

    pmm_table #(.WIDTH(CODE_W), .DEPTH(PAGES)) u_perms (
        .clk(clk), .rst(rst), .we(perm_we), .widx(perm_idx), .wdata(perm_data),
        .ridx(vpn), .rdata(perm_code));

    pmm_table #(.WIDTH(CODE_W), .DEPTH(PAGES)) u_locks (
        .clk(clk), .rst(rst), .we(lock_we), .widx(lock_idx), .wdata(lock_data),
        .ridx(lock_page), .rdata(lock_code));

    pmm_xlate u_xlate (
        .vaddr(req_vaddr), .map_on(map_on), .frame(frame),
        .real_addr(nxt.addr), .regref(nxt.regref),
        .lock_page(lock_page), .lock_live(lock_live));

    pmm_guard u_guard (
        .kind(kind_e'(req_kind)), .map_on(map_on), .regref(nxt.regref),
        .perm_code(perm_code), .lock_code(lock_code), .key(psd_key),
        .lock_live(lock_live), .cause(nxt.cause));

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            cur       <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign res_addr   = cur.addr;
    assign res_regref = cur.regref;
    assign res_cause  = cur.cause;
    assign res_fault  = (cur.cause != CAUSE_NONE);
endmodule

// File: rtl/page_map_guard_chk.sv
module page_map_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [16:0] req_vaddr,
    input logic        map_on,
    input logic [1:0]  psd_key,
    input logic        res_valid,
    input logic [21:0] res_addr,
    input logic        res_regref,
    input logic        res_fault,
    input logic [1:0]  res_cause
);
    assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> res_valid);
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rst) |=> !res_valid);
    assert_regref_clean_R1: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_regref) |-> !res_fault);
    assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !map_on && !rst) |=> (res_addr == {5'b0, $past(req_vaddr)}));
    assert_master_key_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !map_on && psd_key == 2'b00 && !rst) |=> !res_fault);
    assert_cause_flag_R7: assert property (@(posedge clk) disable iff (rst)
        res_fault == (res_cause != 2'b00));
    assert_cause_single_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(res_cause));
endmodule

bind page_map_guard page_map_guard_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .map_on(map_on), .psd_key(psd_key), .res_valid(res_valid),
    .res_addr(res_addr), .res_regref(res_regref), .res_fault(res_fault),
    .res_cause(res_cause));

// File: tb/page_map_guard_test.sv
module page_map_guard_test;
    logic        clk = 0, rst = 1;
    logic        req_valid = 0;
    logic [16:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        map_on = 0;
    logic [1:0]  psd_key = '0;
    logic        frm_we = 0, perm_we = 0, lock_we = 0;
    logic [7:0]  frm_idx = '0, perm_idx = '0, lock_idx = '0;
    logic [12:0] frm_data = '0;
    logic [1:0]  perm_data = '0, lock_data = '0;
    logic        res_valid, res_regref, res_fault;
    logic [21:0] res_addr;
    logic [1:0]  res_cause;

    always #5 clk = ~clk;

    page_map_guard uut (.*);

    typedef struct {
        logic [21:0] addr;
        logic        regref;
        logic [1:0]  cause;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0, n_bad = 0;
    logic [12:0] m_frm [256];
    logic [1:0]  m_perm [256];
    logic [1:0]  m_lock [256];

    function automatic exp_t predict(logic [16:0] va, logic [1:0] k, logic mo,
                                     logic [1:0] key, string tag);
        exp_t e;
        logic pf, lf;
        logic [1:0] c;
        e.tag = tag;
        e.regref = (va < 17'd16);
        if (e.regref || !mo) e.addr = {5'b0, va};
        else e.addr = {m_frm[va[16:9]], va[8:0]};
        c = m_perm[va[16:9]];
        case (k)
            2'b00:   pf = (c == 2'b11);
            2'b10:   pf = !(c == 2'b00 || c == 2'b01);
            default: pf = (c != 2'b00);
        endcase
        pf = pf && mo;
        lf = (e.addr < 22'h20000) && m_lock[e.addr[16:9]] != 0 && key != 0
             && key != m_lock[e.addr[16:9]];
        e.cause = e.regref ? 2'b00 : pf ? 2'b01 : lf ? 2'b10 : 2'b00;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_we();
        frm_we = 0; perm_we = 0; lock_we = 0;
    endtask

    task automatic lookup(logic [16:0] va, logic [1:0] k, logic mo, logic [1:0] key, string tag);
        @(negedge clk);
        clear_we();
        req_valid = 1; req_vaddr = va; req_kind = k; map_on = mo; psd_key = key;
        q.push_back(predict(va, k, mo, key, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        clear_we();
        req_valid = 0;
    endtask

    task automatic set_frame(logic [7:0] i, logic [12:0] d);
        @(negedge clk);
        clear_we(); req_valid = 0;
        frm_we = 1; frm_idx = i; frm_data = d; m_frm[i] = d;
    endtask

    task automatic set_perm(logic [7:0] i, logic [1:0] d);
        @(negedge clk);
        clear_we(); req_valid = 0;
        perm_we = 1; perm_idx = i; perm_data = d; m_perm[i] = d;
    endtask

    task automatic set_lock(logic [7:0] i, logic [1:0] d);
        @(negedge clk);
        clear_we(); req_valid = 0;
        lock_we = 1; lock_idx = i; lock_data = d; m_lock[i] = d;
    endtask

    // monitor: pops one expected item per result
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                check("R8 unexpected result", 32'(res_valid), 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " addr"}, 32'(res_addr), 32'(e.addr));
                check({e.tag, " regref"}, 32'(res_regref), 32'(e.regref));
                check({e.tag, " cause"}, 32'(res_cause), 32'(e.cause));
                check({e.tag, " fault"}, 32'(res_fault), 32'(e.cause != 0));
            end
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_frm[i] = '0; m_perm[i] = '0; m_lock[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: outputs after reset
        @(negedge clk);
        check("R10 valid", 32'(res_valid), 0);
        check("R10 addr", 32'(res_addr), 0);
        check("R10 fault", 32'(res_fault), 0);
        // R10: frame entries cleared -> page 5 maps to frame 0
        lookup({8'd5, 9'h0AA}, 2'b00, 1'b1, 2'b00, "R10 cleared frame");
        // R3: passthrough
        lookup(17'h1234, 2'b01, 1'b0, 2'b00, "R3 passthrough");
        // R1: register references even with no-access code
        set_perm(8'd0, 2'b11);
        lookup(17'd5, 2'b01, 1'b1, 2'b01, "R1 reg 5");
        lookup(17'd15, 2'b10, 1'b1, 2'b11, "R1 reg 15");
        lookup(17'd16, 2'b00, 1'b1, 2'b00, "R1 first non-reg R4");
        idle();
        // R8: gap produces no result
        @(negedge clk);
        check("R8 idle", 32'(res_valid), 0);
        // R2: translation into high frame
        set_frame(8'd3, 13'h1ABC);
        lookup({8'd3, 9'h055}, 2'b00, 1'b1, 2'b00, "R2 translate");
        // R4: permission codes
        set_perm(8'd3, 2'b01);
        lookup({8'd3, 9'h001}, 2'b01, 1'b1, 2'b00, "R4 rx write");
        lookup({8'd3, 9'h002}, 2'b10, 1'b1, 2'b00, "R4 rx exec");
        lookup({8'd3, 9'h003}, 2'b11, 1'b1, 2'b00, "R4 rx kind11");
        set_perm(8'd3, 2'b10);
        lookup({8'd3, 9'h004}, 2'b10, 1'b1, 2'b00, "R4 ro exec");
        lookup({8'd3, 9'h005}, 2'b00, 1'b1, 2'b00, "R4 ro read");
        set_perm(8'd3, 2'b11);
        lookup({8'd3, 9'h006}, 2'b00, 1'b1, 2'b00, "R4 none read");
        lookup({8'd3, 9'h006}, 2'b00, 1'b0, 2'b00, "R3 code ignored");
        set_perm(8'd3, 2'b00);
        lookup({8'd3, 9'h007}, 2'b01, 1'b1, 2'b00, "R4 all write");
        // R5: lock and key
        set_frame(8'd4, 13'h0007);
        set_lock(8'd7, 2'b10);
        lookup({8'd4, 9'h010}, 2'b00, 1'b1, 2'b01, "R5 key mismatch");
        lookup({8'd4, 9'h011}, 2'b00, 1'b1, 2'b10, "R5 key match");
        lookup({8'd4, 9'h012}, 2'b00, 1'b1, 2'b00, "R5 master key");
        lookup({8'd7, 9'h013}, 2'b00, 1'b0, 2'b11, "R5 unmapped lock");
        set_lock(8'd7, 2'b00);
        lookup({8'd4, 9'h014}, 2'b00, 1'b1, 2'b11, "R5 open lock");
        // R6: high real address skips lock
        set_lock(8'hBC, 2'b11);
        lookup({8'd3, 9'h020}, 2'b00, 1'b1, 2'b01, "R6 above lock span");
        // R7: both fail -> permission cause
        set_lock(8'd7, 2'b11);
        set_perm(8'd4, 2'b11);
        lookup({8'd4, 9'h030}, 2'b00, 1'b1, 2'b01, "R7 both fail");
        // R9: same-cycle write and lookup
        @(negedge clk);
        clear_we();
        q.push_back(predict({8'd6, 9'h040}, 2'b00, 1'b1, 2'b00, "R9 old entry"));
        req_valid = 1; req_vaddr = {8'd6, 9'h040}; req_kind = 2'b00; map_on = 1; psd_key = 0;
        frm_we = 1; frm_idx = 8'd6; frm_data = 13'h0ACE; m_frm[6] = 13'h0ACE;
        lookup({8'd6, 9'h041}, 2'b00, 1'b1, 2'b00, "R9 new entry");
        idle();
        repeat (3) @(negedge clk);
        check("R8 queue drained", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule